// File: doc/BRIEF.md
# ALU with Background Multiply and Divide

This block is the arithmetic engine of an integer datapath. A single-cycle path handles logic, add/subtract and shift operations. Two multicycle units run beside it: a signed multiplier and a signed restoring divider. Issuing logic starts a multiply or a divide through dedicated control inputs. While the background unit computes, the single-cycle path keeps accepting new operations. The result is collected later with a pickup opcode, and a select field chooses which multiplier form or divider output to read.

All operands are 32-bit two's complement by default. Each operation produces a result and six flags: carry, divide-by-zero, negative, overflow, extend and zero. For extended-precision sequences the zero flag can be chained with an incoming zero flag. If a background result is picked up before it is ready, the block returns zero and raises an error line. The issuing logic must space multiply and divide starts apart, because the block does no hazard checking.

Top module: `bgmd_alu`

## Requirements
- R1: The logic codes give these results: 0 OR, 1 AND, 2 NOR, 3 NAND, 4 XOR, 5 constant zero, 6 XNOR, 7 all ones. Carry and overflow are 0 for them.
- R2: Adder codes are 8 ADD (a+b), 9 ADDC (a+b+carry_in), 10 SUB (a+~b+1), 11 SUBC (a+~b+carry_in) and 12 CMP (same as SUB). For these, carry_out is the carry out of that 33-bit sum and ovf_out is signed overflow. ADD, SUB and CMP ignore carry_in and ext_in.
- R3: The shift amount is opb[4:0]. Code 13 is a logical right shift, 14 an arithmetic right shift, 15 a right shift that fills the vacated top bits with ext_in, and 16 a rotate right. For every code, ext_out is opa[amount-1], or 0 when the amount is 0.
- R4: zero_out is (result==0) AND zero_in for ADDC, SUBC and the multiply high-word pickup. For every other operation it is (result==0).
- R5: neg_out equals result bit 31 and divz_out is 1 exactly when opb is zero. Both hold for every operation.
- R6: While mul_start_n is 0, the multiplier latches opa and opb. The product can be picked up from the second cycle after the latch edge, provided mul_start_n is 1 during pickup. It stays readable until the next start.
- R7: Code 17 picks up a background result according to md_sel. md_sel 0 with md_acc 0 gives the low word of the signed product. md_sel 0 with md_acc 1 gives the low word plus the current opa. md_sel 1 gives the high word of the signed product. md_sel 2 gives the divider output. Code 18 and unused codes give result 0.
- R8: div_start=1 latches the dividend (opa) and divisor (opb). The quotient is readable during cycles 67 and 68 after the latch edge. From cycle 69 the remainder is readable, and it stays until the next start.
- R9: Division truncates toward zero and the remainder takes the sign of the dividend. A zero divisor gives quotient all ones and remainder equal to the dividend.
- R10: A pickup with nothing ready, or with md_sel 3, drives result 0 and md_err 1. md_err is 0 for all other operations. Carry and overflow are 0 for pickups.
- R11: After synchronous active-low reset, no operands are latched, so any multiply or divide pickup reports md_err.
- R12: The single-cycle path gives correct results while a divide is in progress, and the divide result is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 5 | Operation code |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| carry_in | input | 1 | Incoming carry |
| ext_in | input | 1 | Incoming extend bit (fill for extended shift) |
| zero_in | input | 1 | Incoming zero flag for chaining |
| mul_start_n | input | 1 | Multiplier start, active low |
| div_start | input | 1 | Divider start, active high |
| md_sel | input | 2 | Background result select |
| md_acc | input | 1 | Accumulate variant of the low product |
| result | output | 32 | Result |
| carry_out | output | 1 | Carry flag |
| divz_out | output | 1 | Divisor-is-zero flag |
| neg_out | output | 1 | Negative flag |
| ovf_out | output | 1 | Signed overflow flag |
| ext_out | output | 1 | Last bit shifted out |
| zero_out | output | 1 | Zero flag, optionally chained |
| md_err | output | 1 | Pickup of a result that is not ready |

## Verification
Four properties are checked on every cycle. A start never makes a result readable on the very next cycle. The divider counter only reaches its remainder step by passing through the quotient step. A pickup error always comes with a zero result. A raised zero flag always comes with a zero result. The bench scenarios are the only place that shows the arithmetic itself. They cover the flag values of each code, the chaining of the zero flag, and the signs of the quotient and remainder. They also cover the exact first and last pickup cycles of the quotient window, and an ALU operation issued in the middle of a running divide.

// File: rtl/bgmd_alu_pkg.sv
// Shared operation codes and pickup selects for the background
// multiply/divide ALU. Encodings are fixed: issuing logic depends on them.
package bgmd_alu_pkg;
    localparam logic [4:0] OP_OR   = 5'd0;
    localparam logic [4:0] OP_AND  = 5'd1;
    localparam logic [4:0] OP_NOR  = 5'd2;
    localparam logic [4:0] OP_NAND = 5'd3;
    localparam logic [4:0] OP_XOR  = 5'd4;
    localparam logic [4:0] OP_ZERO = 5'd5;
    localparam logic [4:0] OP_XNOR = 5'd6;
    localparam logic [4:0] OP_ONES = 5'd7;
    localparam logic [4:0] OP_ADD  = 5'd8;
    localparam logic [4:0] OP_ADDC = 5'd9;
    localparam logic [4:0] OP_SUB  = 5'd10;
    localparam logic [4:0] OP_SUBC = 5'd11;
    localparam logic [4:0] OP_CMP  = 5'd12;
    localparam logic [4:0] OP_LSH  = 5'd13;
    localparam logic [4:0] OP_ASH  = 5'd14;
    localparam logic [4:0] OP_XSH  = 5'd15;
    localparam logic [4:0] OP_ROT  = 5'd16;
    localparam logic [4:0] OP_MDRD = 5'd17;
    localparam logic [4:0] OP_NOP  = 5'd18;

    localparam logic [1:0] SEL_MUL_LO = 2'd0;
    localparam logic [1:0] SEL_MUL_HI = 2'd1;
    localparam logic [1:0] SEL_DIV    = 2'd2;
endpackage

// File: rtl/bgmd_alu_path.sv
// Single-cycle path: logic, adder and shift operations.
// Purely combinational. Assumes W is a power of two; the shift amount
// uses the low log2(W) bits of b.
module bgmd_alu_path
    import bgmd_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [4:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         xin,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         ovf,
    output logic         ext
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] amt;
    logic [W-1:0]   b_eff;
    logic           c_eff;
    logic [W:0]     sum;
    logic           is_adder;
    logic [W-1:0]   lsh_v, ash_v, xsh_v, rot_v, fill_mask;

    assign amt = b[SHW-1:0];

    // Choose the second adder operand and its carry for each adder code.
    always_comb begin : adder_setup
        b_eff = b;
        c_eff = 1'b0;
        case (op)
            OP_ADDC:        c_eff = cin;
            OP_SUB, OP_CMP: begin b_eff = ~b; c_eff = 1'b1; end
            OP_SUBC:        begin b_eff = ~b; c_eff = cin;  end
            default:        ;
        endcase
    end

    assign sum      = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    assign is_adder = (op >= OP_ADD) && (op <= OP_CMP);

    assign lsh_v     = a >> amt;
    assign ash_v     = $signed(a) >>> amt;
    assign fill_mask = ~({W{1'b1}} >> amt);
    assign xsh_v     = lsh_v | (xin ? fill_mask : {W{1'b0}});
    assign rot_v     = lsh_v | (a << (W - int'(amt)));
    assign ext       = (amt != '0) ? a[amt - 1'b1] : 1'b0;

    // Result multiplexer across all single-cycle codes.
    always_comb begin : result_mux
        case (op)
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_NOR:  res = ~(a | b);
            OP_NAND: res = ~(a & b);
            OP_XOR:  res = a ^ b;
            OP_ZERO: res = '0;
            OP_XNOR: res = ~(a ^ b);
            OP_ONES: res = '1;
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: res = sum[W-1:0];
            OP_LSH:  res = lsh_v;
            OP_ASH:  res = ash_v;
            OP_XSH:  res = xsh_v;
            OP_ROT:  res = rot_v;
            default: res = '0;
        endcase
    end

    // Carry and signed overflow exist only for adder codes.
    always_comb begin : adder_flags
        carry = is_adder & sum[W];
        ovf   = is_adder & (a[W-1] == b_eff[W-1]) & (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/bgmd_alu_mul.sv
// Background signed multiplier. A low start_n latches both operands.
// The full 2W product is registered one cycle later, and the result can be
// read from the second cycle after the latch while start_n stays high.
// Assumes starts are spaced at least three cycles apart.
module bgmd_alu_mul #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_n,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel_hi,
    input  logic         acc_en,
    input  logic [W-1:0] addend,
    output logic         ready,
    output logic [W-1:0] res
);
    localparam logic [1:0] STEP_DONE = 2'd2;

    logic [W-1:0]   op_a, op_b;
    logic           have_ops;
    logic [1:0]     step;
    logic [2*W-1:0] prod;

    // Latch operands on start, then count up to the ready step.
    always_ff @(posedge clk) begin : mul_ctrl
        if (!rst_n) begin
            op_a     <= '0;
            op_b     <= '0;
            have_ops <= 1'b0;
            step     <= '0;
        end else if (!start_n) begin
            op_a     <= a;
            op_b     <= b;
            have_ops <= 1'b1;
            step     <= 2'd1;
        end else if (have_ops && step != STEP_DONE) begin
            step <= step + 2'd1;
        end
    end

    // Register the full signed product during step 1.
    always_ff @(posedge clk) begin : mul_prod
        if (!rst_n) begin
            prod <= '0;
        end else if (step == 2'd1) begin
            prod <= $signed({{W{op_a[W-1]}}, op_a}) * $signed({{W{op_b[W-1]}}, op_b});
        end
    end

    assign ready = start_n && have_ops && (step == STEP_DONE);

    // Pick the high word, the low word, or the low word plus an addend.
    always_comb begin : mul_form
        if (sel_hi)      res = prod[2*W-1:W];
        else if (acc_en) res = prod[W-1:0] + addend;
        else             res = prod[W-1:0];
    end

    // R6: the result is never readable on the cycle right after a start.
    assert_mul_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !start_n |=> !ready);
endmodule

// File: rtl/bgmd_alu_div.sv
// Background signed restoring divider, one quotient bit per step.
// The step counter advances every other cycle. Steps 1..W iterate,
// step W+1 applies signs, the quotient reads at step W+2 and the
// remainder at step W+3.
// Assumes a new start is not issued while a pickup is still pending.
module bgmd_alu_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         q_ready,
    output logic         r_ready,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 4);
    localparam logic [CW-1:0] LAST_ITER = CW'(W);
    localparam logic [CW-1:0] FIX_STEP  = CW'(W + 1);
    localparam logic [CW-1:0] Q_STEP    = CW'(W + 2);
    localparam logic [CW-1:0] R_STEP    = CW'(W + 3);

    logic [CW-1:0] step;
    logic          tick, have_ops, neg_q, neg_r, dz;
    logic [W-1:0]  quo_r, rem_r, dvs;
    logic [W:0]    shifted, trial;
    logic          iterate, fixup;

    assign shifted = {rem_r, quo_r[W-1]};
    assign trial   = shifted - {1'b0, dvs};
    assign iterate = tick && (step != '0) && (step <= LAST_ITER);
    assign fixup   = tick && (step == FIX_STEP);

    // Step counter with the half-rate tick.
    always_ff @(posedge clk) begin : div_count
        if (!rst_n) begin
            step     <= '0;
            tick     <= 1'b0;
            have_ops <= 1'b0;
        end else if (start) begin
            step     <= {{(CW-1){1'b0}}, 1'b1};
            tick     <= 1'b0;
            have_ops <= 1'b1;
        end else begin
            tick <= ~tick;
            if (tick && have_ops && step != R_STEP) step <= step + 1'b1;
        end
    end

    // Operand magnitudes, the shift-subtract iterations and the sign fix.
    always_ff @(posedge clk) begin : div_data
        if (!rst_n) begin
            quo_r <= '0;
            rem_r <= '0;
            dvs   <= '0;
            neg_q <= 1'b0;
            neg_r <= 1'b0;
            dz    <= 1'b0;
        end else if (start) begin
            quo_r <= a[W-1] ? -a : a;
            dvs   <= b[W-1] ? -b : b;
            rem_r <= '0;
            neg_q <= a[W-1] ^ b[W-1];
            neg_r <= a[W-1];
            dz    <= (b == '0);
        end else if (iterate) begin
            if (!trial[W]) begin
                rem_r <= trial[W-1:0];
                quo_r <= {quo_r[W-2:0], 1'b1};
            end else begin
                rem_r <= shifted[W-1:0];
                quo_r <= {quo_r[W-2:0], 1'b0};
            end
        end else if (fixup) begin
            quo_r <= dz ? '1 : (neg_q ? -quo_r : quo_r);
            rem_r <= neg_r ? -rem_r : rem_r;
        end
    end

    assign q_ready = !start && have_ops && (step == Q_STEP);
    assign r_ready = !start && have_ops && (step == R_STEP);
    assign quo     = quo_r;
    assign rem     = rem_r;

    // R8: nothing is readable on the cycle right after a start.
    assert_div_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!q_ready && !r_ready));
    // R8: the remainder step is only reached from the quotient step.
    assert_div_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step == R_STEP) |-> $past(step == Q_STEP));
endmodule

// File: rtl/bgmd_alu.sv
// Top: single-cycle path plus background multiplier and divider.
// Chooses between the path result and a background pickup, and builds
// the flags, including the chained zero flag.
// Assumes the issuing logic spaces starts and pickups correctly.
module bgmd_alu
    import bgmd_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [4:0]   op_code,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         carry_in,
    input  logic         ext_in,
    input  logic         zero_in,
    input  logic         mul_start_n,
    input  logic         div_start,
    input  logic [1:0]   md_sel,
    input  logic         md_acc,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         divz_out,
    output logic         neg_out,
    output logic         ovf_out,
    output logic         ext_out,
    output logic         zero_out,
    output logic         md_err
);
    logic [W-1:0] path_res, mul_res, div_quo, div_rem;
    logic         path_c, path_v, path_x;
    logic         mul_rdy, q_rdy, r_rdy;
    logic         is_md, zero_chain;

    assign is_md = (op_code == OP_MDRD);

    bgmd_alu_path #(.W(W)) u_path (
        .op(op_code), .a(opa), .b(opb), .cin(carry_in), .xin(ext_in),
        .res(path_res), .carry(path_c), .ovf(path_v), .ext(path_x)
    );

    bgmd_alu_mul #(.W(W)) u_mul (
        .clk(clk), .rst_n(rst_n), .start_n(mul_start_n), .a(opa), .b(opb),
        .sel_hi(md_sel == SEL_MUL_HI), .acc_en(md_acc), .addend(opa),
        .ready(mul_rdy), .res(mul_res)
    );

    bgmd_alu_div #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .a(opa), .b(opb),
        .q_ready(q_rdy), .r_ready(r_rdy), .quo(div_quo), .rem(div_rem)
    );

    // Merge the path result with a background pickup.
    always_comb begin : output_select
        result    = path_res;
        carry_out = path_c;
        ovf_out   = path_v;
        md_err    = 1'b0;
        if (is_md) begin
            carry_out = 1'b0;
            ovf_out   = 1'b0;
            result    = '0;
            case (md_sel)
                SEL_MUL_LO, SEL_MUL_HI: begin
                    if (mul_rdy) result = mul_res;
                    else         md_err = 1'b1;
                end
                SEL_DIV: begin
                    if (q_rdy)      result = div_quo;
                    else if (r_rdy) result = div_rem;
                    else            md_err = 1'b1;
                end
                default: md_err = 1'b1;
            endcase
        end
    end

    // Flags built from the final result and the operands.
    always_comb begin : flag_build
        zero_chain = (op_code == OP_ADDC) || (op_code == OP_SUBC) ||
                     (is_md && md_sel == SEL_MUL_HI);
        zero_out   = (result == '0) && (!zero_chain || zero_in);
        neg_out    = result[W-1];
        divz_out   = (opb == '0);
        ext_out    = path_x;
    end

    // R10: an early or invalid pickup returns zero.
    assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        md_err |-> (result == '0));
    // R4: the zero flag is never raised over a nonzero result.
    assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        zero_out |-> (result == '0));
endmodule

// File: tb/bgmd_alu_bench.sv
module bgmd_alu_bench;
    localparam int PERIOD = 10;
    localparam int W = 32;

    localparam logic [4:0] C_ADD = 5'd8, C_MDRD = 5'd17, C_NOP = 5'd18;

    typedef struct packed {
        logic [4:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic        cin, xin, zin;
        logic [31:0] res;
        logic        c, v, z, n, x;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [0:NV-1] = '{
        '{5'd0,  32'hF0F0_0000, 32'h0F0F_0000, 1'b0,1'b0,1'b0, 32'hFFFF_0000, 1'b0,1'b0,1'b0,1'b1,1'b0, 4'd1}, // R1 OR
        '{5'd1,  32'hFF00_FF00, 32'h0FF0_0FE0, 1'b0,1'b0,1'b0, 32'h0F00_0F00, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd1}, // R1 AND
        '{5'd2,  32'h0,         32'h0,         1'b0,1'b0,1'b0, 32'hFFFF_FFFF, 1'b0,1'b0,1'b0,1'b1,1'b0, 4'd1}, // R1 NOR
        '{5'd3,  32'hFFFF_FFFF, 32'hFFFF_FFE0, 1'b0,1'b0,1'b0, 32'h0000_001F, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd1}, // R1 NAND
        '{5'd4,  32'h1234_5678, 32'h1234_5660, 1'b0,1'b0,1'b0, 32'h0000_0018, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd1}, // R1 XOR
        '{5'd5,  32'hFFFF_FFFF, 32'hFFFF_FFE0, 1'b1,1'b1,1'b0, 32'h0,         1'b0,1'b0,1'b1,1'b0,1'b0, 4'd1}, // R1 ZERO
        '{5'd6,  32'hAAAA_AAAA, 32'h5555_5540, 1'b0,1'b0,1'b0, 32'h0000_0015, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd1}, // R1 XNOR
        '{5'd7,  32'h0,         32'h0,         1'b0,1'b0,1'b0, 32'hFFFF_FFFF, 1'b0,1'b0,1'b0,1'b1,1'b0, 4'd1}, // R1 ONES
        '{5'd8,  32'h7FFF_FFFF, 32'h1,         1'b1,1'b1,1'b0, 32'h8000_0000, 1'b0,1'b1,1'b0,1'b1,1'b1, 4'd2}, // R2 ADD overflow, cin ignored
        '{5'd8,  32'hFFFF_FFFF, 32'h1,         1'b0,1'b0,1'b0, 32'h0,         1'b1,1'b0,1'b1,1'b0,1'b1, 4'd2}, // R2 ADD carry
        '{5'd9,  32'hFFFF_FFFF, 32'h0,         1'b1,1'b0,1'b1, 32'h0,         1'b1,1'b0,1'b1,1'b0,1'b0, 4'd4}, // R4 ADDC chained zero
        '{5'd9,  32'hFFFF_FFFF, 32'h0,         1'b1,1'b0,1'b0, 32'h0,         1'b1,1'b0,1'b0,1'b0,1'b0, 4'd4}, // R4 ADDC zero_in low
        '{5'd10, 32'h5,         32'h7,         1'b0,1'b0,1'b0, 32'hFFFF_FFFE, 1'b0,1'b0,1'b0,1'b1,1'b0, 4'd2}, // R2 SUB borrow
        '{5'd11, 32'hA,         32'h3,         1'b0,1'b0,1'b1, 32'h6,         1'b1,1'b0,1'b0,1'b0,1'b0, 4'd2}, // R2 SUBC
        '{5'd12, 32'h8000_0000, 32'h1,         1'b0,1'b0,1'b0, 32'h7FFF_FFFF, 1'b1,1'b1,1'b0,1'b0,1'b0, 4'd2}, // R2 CMP overflow
        '{5'd13, 32'h8000_0001, 32'h4,         1'b0,1'b1,1'b0, 32'h0800_0000, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd3}, // R3 logical
        '{5'd14, 32'h8000_0010, 32'h4,         1'b0,1'b0,1'b0, 32'hF800_0001, 1'b0,1'b0,1'b0,1'b1,1'b0, 4'd3}, // R3 arithmetic
        '{5'd15, 32'h0000_00F0, 32'h4,         1'b0,1'b1,1'b0, 32'hF000_000F, 1'b0,1'b0,1'b0,1'b1,1'b0, 4'd3}, // R3 extended, fill 1
        '{5'd15, 32'h0000_00F0, 32'h4,         1'b0,1'b0,1'b0, 32'h0000_000F, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd3}, // R3 extended, fill 0
        '{5'd16, 32'h0000_0013, 32'h2,         1'b0,1'b0,1'b0, 32'hC000_0004, 1'b0,1'b0,1'b0,1'b1,1'b1, 4'd3}, // R3 rotate
        '{5'd16, 32'h1234_5678, 32'h20,        1'b0,1'b0,1'b0, 32'h1234_5678, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd3}, // R3 amount uses low bits only
        '{5'd14, 32'h8000_0000, 32'd31,        1'b0,1'b0,1'b0, 32'hFFFF_FFFF, 1'b0,1'b0,1'b0,1'b1,1'b0, 4'd3}, // R3 max amount
        '{5'd13, 32'h0,         32'h0,         1'b0,1'b0,1'b1, 32'h0,         1'b0,1'b0,1'b1,1'b0,1'b0, 4'd4}, // R4 unchained zero
        '{5'd18, 32'h0,         32'h0,         1'b0,1'b0,1'b0, 32'h0,         1'b0,1'b0,1'b1,1'b0,1'b0, 4'd7}  // R7 NOP
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_code = 5'd18;
    logic [31:0] opa = '0, opb = '0;
    logic        carry_in = 1'b0, ext_in = 1'b0, zero_in = 1'b0;
    logic        mul_start_n = 1'b1, div_start = 1'b0, md_acc = 1'b0;
    logic [1:0]  md_sel = 2'd0;
    logic [31:0] result;
    logic        carry_out, divz_out, neg_out, ovf_out, ext_out, zero_out, md_err;

    int tests = 0;
    int fails = 0;

    always #(PERIOD/2) clk = ~clk;

    bgmd_alu #(.W(W)) u_bgmd_alu (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .opa(opa), .opb(opb),
        .carry_in(carry_in), .ext_in(ext_in), .zero_in(zero_in),
        .mul_start_n(mul_start_n), .div_start(div_start), .md_sel(md_sel),
        .md_acc(md_acc), .result(result), .carry_out(carry_out),
        .divz_out(divz_out), .neg_out(neg_out), .ovf_out(ovf_out),
        .ext_out(ext_out), .zero_out(zero_out), .md_err(md_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Pickup with given select; compares {result, md_err, neg_out}.
    task automatic pickup(input string tag, input logic [1:0] sel, input logic acc,
                          input logic [31:0] exp_res, input logic exp_err);
        op_code = C_MDRD; md_sel = sel; md_acc = acc;
        #1 check(tag, {30'd0, result, md_err, neg_out}, {30'd0, exp_res, exp_err, exp_res[31]});
    endtask

    task automatic run_div(input string tag, input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] q, input logic [31:0] r);
        @(negedge clk);
        op_code = C_NOP; opa = a; opb = b; div_start = 1'b1;
        #1 check({tag, " R5 divz"}, {63'd0, divz_out}, {63'd0, (b == 32'd0)});
        @(negedge clk);                              // cycle 1 after latch
        div_start = 1'b0;
        for (int i = 2; i <= 66; i++) begin
            @(negedge clk);
            if (i == 10) begin
                // R12: single-cycle ADD while the divide runs
                op_code = C_ADD; opa = 32'd2; opb = 32'd3;
                #1 check({tag, " R12 add during divide"}, {32'd0, result}, 64'd5);
                op_code = C_NOP;
            end
        end
        pickup({tag, " R8 early pickup"}, 2'd2, 1'b0, 32'd0, 1'b1);       // cycle 66
        @(negedge clk); pickup({tag, " R8 quotient first"}, 2'd2, 1'b0, q, 1'b0);
        @(negedge clk); pickup({tag, " R9 quotient last"}, 2'd2, 1'b0, q, 1'b0);
        @(negedge clk); pickup({tag, " R9 remainder"}, 2'd2, 1'b0, r, 1'b0);
        @(negedge clk); pickup({tag, " R8 remainder held"}, 2'd2, 1'b0, r, 1'b0);
        op_code = C_NOP;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state, nothing latched
        pickup("R11 mul pickup after reset", 2'd0, 1'b0, 32'd0, 1'b1);
        pickup("R11 div pickup after reset", 2'd2, 1'b0, 32'd0, 1'b1);

        // Table walk over the single-cycle path
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            op_code = VECS[k].op; opa = VECS[k].a; opb = VECS[k].b;
            carry_in = VECS[k].cin; ext_in = VECS[k].xin; zero_in = VECS[k].zin;
            #1 tests++;
            if ({result, carry_out, ovf_out, zero_out, neg_out, ext_out, divz_out, md_err} !==
                {VECS[k].res, VECS[k].c, VECS[k].v, VECS[k].z, VECS[k].n, VECS[k].x,
                 (VECS[k].b == 32'd0), 1'b0}) begin
                fails++;
                $display("FAIL R%0d row %0d actual=%h_%b%b%b%b%b%b%b expected=%h_%b%b%b%b%b%b0",
                         VECS[k].req, k, result, carry_out, ovf_out, zero_out, neg_out,
                         ext_out, divz_out, md_err, VECS[k].res, VECS[k].c, VECS[k].v,
                         VECS[k].z, VECS[k].n, VECS[k].x, (VECS[k].b == 32'd0));
            end
        end
        carry_in = 1'b0; ext_in = 1'b0; zero_in = 1'b0;

        // R6, R7: multiply 7 * 6
        @(negedge clk);
        op_code = C_NOP; opa = 32'd7; opb = 32'd6; mul_start_n = 1'b0;
        @(negedge clk);
        mul_start_n = 1'b1;
        pickup("R6 not ready one cycle after start", 2'd0, 1'b0, 32'd0, 1'b1);
        @(negedge clk);
        pickup("R6 low product ready", 2'd0, 1'b0, 32'd42, 1'b0);
        opa = 32'd100;
        pickup("R7 accumulate form", 2'd0, 1'b1, 32'd142, 1'b0);
        zero_in = 1'b1;
        pickup("R7 high word", 2'd1, 1'b0, 32'd0, 1'b0);
        #1 check("R4 high word chained zero", {63'd0, zero_out}, 64'd1);
        zero_in = 1'b0;
        #1 check("R4 high word zero_in low", {63'd0, zero_out}, 64'd0);
        @(negedge clk);
        pickup("R6 product held", 2'd0, 1'b0, 32'd42, 1'b0);
        pickup("R10 reserved select", 2'd3, 1'b0, 32'd0, 1'b1);
        op_code = C_ADD; opa = 32'd1; opb = 32'd1;
        #1 check("R10 no error on ALU op", {63'd0, md_err}, 64'd0);

        // R7: signed product -3 * 5
        @(negedge clk);
        op_code = C_NOP; opa = 32'hFFFF_FFFD; opb = 32'd5; mul_start_n = 1'b0;
        pickup("R10 pickup during start", 2'd0, 1'b0, 32'd0, 1'b1);
        @(negedge clk); mul_start_n = 1'b1; op_code = C_NOP;
        @(negedge clk);
        pickup("R7 negative low", 2'd0, 1'b0, 32'hFFFF_FFF1, 1'b0);
        pickup("R7 negative high", 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b0);
        @(negedge clk);
        op_code = C_NOP; opa = 32'h0001_0000; opb = 32'h0001_0000; mul_start_n = 1'b0;
        @(negedge clk); mul_start_n = 1'b1;
        @(negedge clk);
        pickup("R7 carry into high word", 2'd1, 1'b0, 32'd1, 1'b0);
        pickup("R7 low word zero", 2'd0, 1'b0, 32'd0, 1'b0);

        // R8, R9, R12: divider
        run_div("div -100/7", 32'hFFFF_FF9C, 32'd7, 32'hFFFF_FFF2, 32'hFFFF_FFFE);
        run_div("div 100/-7", 32'd100, 32'hFFFF_FFF9, 32'hFFFF_FFF2, 32'd2);
        run_div("div 9/0",    32'd9,   32'd0,         32'hFFFF_FFFF, 32'd9);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule